// File: doc/BRIEF.md
# Way-Predicting Set-Associative Cache Lookup

This block is the lookup controller of a set-associative cache that saves read energy by opening a single way on the first access cycle. For every set it remembers the way that was used last. A new request reads only that way's tag and data. If the tag matches, the response is returned after one cycle. If the tag does not match, one extra probe cycle opens every other way of the same set. A hit in that probe answers the request and moves the set's prediction to the matching way. A miss in the probe raises a refill request to the next memory level and waits for the line.

The refilled line goes into the least recently used way of the set, and that way becomes the set's new prediction. Each response carries a latency class, so the caller and the testbench can tell apart the three outcomes: first-cycle hit, probe hit and refill. The tag/data banks, the prediction table and the recency state are inside the block. The per-way enable vector is brought out as a port, so the energy-relevant access pattern can be seen.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, miss_req and way_en are 0, every line is invalid, every set predicts way 0, and the recency order of each set ranks way k as having age k (way WAYS-1 oldest).
- R2: In a cycle where the controller is idle and req_valid is high, way_en has exactly one bit set, at the set's predicted way. When the controller is idle and no request is present, way_en is 0.
- R3: When the predicted way holds a valid matching tag, rsp_valid is high in the cycle right after acceptance, with the line's data and rsp_class 0.
- R4: On a first-cycle miss, the following cycle enables every way except the predicted one. If one of those ways matches, rsp_valid is high in the next cycle with rsp_class 1 and that line's data.
- R5: When the probe also misses, miss_req rises with miss_addr equal to the request address. Both hold, with way_en 0, until fill_valid is sampled high. rsp_valid then follows one cycle later with fill_data and rsp_class 2.
- R6: After any hit or refill, the set's prediction is the way that hit or was filled.
- R7: A refill replaces the way with the greatest age in its set. Any access to a way sets its age to 0 and adds one to the age of every way in the set that was younger than it.
- R8: req_ready is low from the cycle after a first-cycle miss until the cycle after the response.
- R9: rsp_valid is high for one cycle per request and is low when no request was accepted on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Controller idle, request is taken on this edge |
| req_addr | input | TAG_W+log2(SETS) | Request address, set index in the low bits |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | DATA_W | Response line data |
| rsp_class | output | 2 | 0 first-cycle hit, 1 probe hit, 2 refill |
| way_en | output | WAYS | Per-way tag/data read enables for this cycle |
| miss_req | output | 1 | Refill request to the next level |
| miss_addr | output | TAG_W+log2(SETS) | Address of the line to refill |
| fill_valid | input | 1 | Refill data present |
| fill_data | input | DATA_W | Refill line data |

## Verification
The bench builds the block with 4 sets, 4 ways and a 4-bit tag, so the address space is only 64 lines and can be swept completely more than once. With sixteen tags competing for four ways per set, the sweeps quickly reach all of these cases: cold misses, evictions of every way position, probe hits at each non-predicted way and repeated first-cycle hits. A recency and prediction model in the bench predicts each response class and data value, and varied refill stall lengths exercise the miss hold behaviour.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        CLS_FIRST  = 2'd0,
        CLS_PROBE  = 2'd1,
        CLS_REFILL = 2'd2
    } lat_class_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_REFILL = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/wp_way_bank.sv
module wp_way_bank #(
    parameter int SETS   = 32,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            data_q[wr_set] <= wr_data;
        end
    end

    // Only an enabled way reads its tag and data.
    assign hit     = rd_en && valid_q[rd_set] && (tag_q[rd_set] == rd_tag);
    assign rd_data = hit ? data_q[rd_set] : '0;

endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
    parameter int SETS = 32,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    output logic [WAY_W-1:0] pred_way,
    input  logic             upd_en,
    input  logic [WAY_W-1:0] upd_way
);

    logic [WAY_W-1:0] pred_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                pred_q[s] <= '0;
            end
        end else if (upd_en) begin
            pred_q[set_i] <= upd_way;
        end
    end

    assign pred_way = pred_q[set_i];

endmodule

// File: rtl/wp_lru.sv
module wp_lru #(
    parameter int SETS = 32,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);

    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[set_i][w] <= '0;
                end else if (age_q[set_i][w] < age_q[set_i][touch_way]) begin
                    age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[set_i][w] == OLDEST) begin
                victim = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
    import wp_pkg::*;
#(
    parameter int SETS   = 32,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int ADDR_W = TAG_W + SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_class,
    output logic [WAYS-1:0]   way_en,
    output logic              miss_req,
    output logic [ADDR_W-1:0] miss_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);

    ctl_state_e        st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WAY_W-1:0]  pwy_q;
    logic [WAY_W-1:0]  vic_q;

    logic [ADDR_W-1:0] lk_addr;
    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic [WAY_W-1:0]  pred_way;
    logic [WAY_W-1:0]  lru_victim;
    logic [WAYS-1:0]   first_mask;
    logic [WAYS-1:0]   probe_mask;
    logic [WAYS-1:0]   hit_vec;
    logic [DATA_W-1:0] bank_data [WAYS];
    logic [DATA_W-1:0] hit_data;
    logic [WAY_W-1:0]  hit_idx;
    logic              any_hit;
    logic              fill_we;
    logic              upd_en;
    logic [WAY_W-1:0]  upd_way;

    assign lk_addr = (st_q == ST_IDLE) ? req_addr : addr_q;
    assign lk_set  = lk_addr[SET_W-1:0];
    assign lk_tag  = lk_addr[ADDR_W-1:SET_W];

    always_comb begin
        first_mask          = '0;
        first_mask[pred_way] = 1'b1;
        probe_mask          = '1;
        probe_mask[pwy_q]   = 1'b0;
        unique case (st_q)
            ST_IDLE:  way_en = req_valid ? first_mask : '0;
            ST_PROBE: way_en = probe_mask;
            default:  way_en = '0;
        endcase
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        wp_way_bank #(
            .SETS  (SETS),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .rd_en  (way_en[w]),
            .rd_set (lk_set),
            .rd_tag (lk_tag),
            .hit    (hit_vec[w]),
            .rd_data(bank_data[w]),
            .wr_en  (fill_we && (vic_q == WAY_W'(w))),
            .wr_set (lk_set),
            .wr_tag (lk_tag),
            .wr_data(fill_data)
        );
    end

    always_comb begin
        hit_idx  = '0;
        hit_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_idx = WAY_W'(w);
            end
            hit_data = hit_data | bank_data[w];
        end
    end

    assign any_hit = |hit_vec;
    assign fill_we = (st_q == ST_REFILL) && fill_valid;
    assign upd_en  = fill_we || (any_hit && (st_q != ST_REFILL));
    assign upd_way = fill_we ? vic_q : hit_idx;

    wp_pred_table #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) u_pred (
        .clk     (clk),
        .rst     (rst),
        .set_i   (lk_set),
        .pred_way(pred_way),
        .upd_en  (upd_en),
        .upd_way (upd_way)
    );

    wp_lru #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) u_lru (
        .clk      (clk),
        .rst      (rst),
        .set_i    (lk_set),
        .touch_en (upd_en),
        .touch_way(upd_way),
        .victim   (lru_victim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            addr_q    <= '0;
            pwy_q     <= '0;
            vic_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_class <= CLS_FIRST;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        pwy_q  <= pred_way;
                        if (any_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= hit_data;
                            rsp_class <= CLS_FIRST;
                        end else begin
                            st_q <= ST_PROBE;
                        end
                    end
                end
                ST_PROBE: begin
                    if (any_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= hit_data;
                        rsp_class <= CLS_PROBE;
                        st_q      <= ST_IDLE;
                    end else begin
                        vic_q <= lru_victim;
                        st_q  <= ST_REFILL;
                    end
                end
                default: begin
                    if (fill_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= fill_data;
                        rsp_class <= CLS_REFILL;
                        st_q      <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign miss_req  = (st_q == ST_REFILL);
    assign miss_addr = addr_q;

endmodule

// File: rtl/wp_cache_lookup_chk.sv
module wp_cache_lookup_chk #(
    parameter int SETS   = 32,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    localparam int ADDR_W = TAG_W + $clog2(SETS)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_class,
    input logic [WAYS-1:0]   way_en,
    input logic              miss_req,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              fill_valid
);

    AST_IDLE_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |-> ($countones(way_en) == 1)); // R2

    AST_IDLE_NO_WAY: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |-> (way_en == '0)); // R2

    AST_FIRST_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=>
            ((rsp_valid && rsp_class == 2'd0) || (!rsp_valid && !req_ready && !miss_req))); // R3

    AST_PROBE_WAYS: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !miss_req) |-> ($countones(way_en) == WAYS - 1)); // R4

    AST_PROBE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !miss_req) |=>
            ((rsp_valid && rsp_class == 2'd1 && req_ready) || (!rsp_valid && miss_req))); // R4

    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (miss_req && !fill_valid) |=> (miss_req && $stable(miss_addr))); // R5

    AST_MISS_NO_WAY: assert property (@(posedge clk) disable iff (rst)
        miss_req |-> (way_en == '0)); // R5

    AST_FILL_RSP: assert property (@(posedge clk) disable iff (rst)
        (miss_req && fill_valid) |=> (rsp_valid && rsp_class == 2'd2 && req_ready)); // R5

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready); // R8

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |=> !rsp_valid); // R9

endmodule

bind wp_cache_lookup wp_cache_lookup_chk #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_class (rsp_class),
    .way_en    (way_en),
    .miss_req  (miss_req),
    .miss_addr (miss_addr),
    .fill_valid(fill_valid)
);

// File: tb/wp_cache_lookup_tb.sv
module wp_cache_lookup_tb;

    localparam int SETS   = 4;
    localparam int WAYS   = 4;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 6;
    localparam int NADDR  = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [1:0]        rsp_class;
    logic [WAYS-1:0]   way_en;
    logic              miss_req;
    logic [ADDR_W-1:0] miss_addr;
    logic              fill_valid = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit m_val  [SETS][WAYS];
    int m_tag  [SETS][WAYS];
    int m_age  [SETS][WAYS];
    int m_pred [SETS];

    always #2 clk = ~clk;

    wp_cache_lookup #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_class (rsp_class),
        .way_en    (way_en),
        .miss_req  (miss_req),
        .miss_addr (miss_addr),
        .fill_valid(fill_valid),
        .fill_data (fill_data)
    );

    function automatic logic [DATA_W-1:0] line_of(input int a);
        return DATA_W'(a * 97 + 11);
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic model_touch(input int s, input int w);
        int old = m_age[s][w];
        for (int k = 0; k < WAYS; k++) begin
            if (k == w) m_age[s][k] = 0;
            else if (m_age[s][k] < old) m_age[s][k] = m_age[s][k] + 1;
        end
        m_pred[s] = w;
    endtask

    task automatic access(input int a, input int stall);
        int s = a % SETS;
        int t = a / SETS;
        int p = m_pred[s];
        int cls;
        int hw = -1;
        if (m_val[s][p] && m_tag[s][p] == t) begin
            cls = 0;
            hw  = p;
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (w != p && m_val[s][w] && m_tag[s][w] == t) hw = w;
            end
            cls = (hw >= 0) ? 1 : 2;
            if (cls == 2) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (m_age[s][w] == WAYS - 1) hw = w;
                end
            end
        end

        @(negedge clk);
        check(way_en == '0, "R2 idle enables", int'(way_en), 0);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(a);
        #1;
        check(req_ready == 1'b1, "R8 ready when idle", int'(req_ready), 1);
        check(way_en == WAYS'(1 << p), "R2 R6 predicted way enable", int'(way_en), 1 << p);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (cls == 0) begin
            check(rsp_valid == 1'b1, "R3 first-cycle rsp_valid", int'(rsp_valid), 1);
            check(rsp_class == 2'd0, "R3 R6 R7 class", int'(rsp_class), 0);
            check(rsp_data == line_of(a), "R3 data", int'(rsp_data), int'(line_of(a)));
        end else begin
            check(rsp_valid == 1'b0, "R4 no early rsp", int'(rsp_valid), 0);
            check(req_ready == 1'b0, "R8 busy in probe", int'(req_ready), 0);
            check(way_en == (WAYS'(4'hF) & ~WAYS'(1 << p)), "R4 probe enables",
                  int'(way_en), int'(WAYS'(4'hF) & ~WAYS'(1 << p)));
            @(posedge clk);
            #1;
            if (cls == 1) begin
                check(rsp_valid == 1'b1, "R4 probe rsp_valid", int'(rsp_valid), 1);
                check(rsp_class == 2'd1, "R4 R6 R7 class", int'(rsp_class), 1);
                check(rsp_data == line_of(a), "R4 data", int'(rsp_data), int'(line_of(a)));
            end else begin
                check(rsp_valid == 1'b0, "R5 no rsp before fill", int'(rsp_valid), 0);
                check(miss_req == 1'b1, "R5 R6 R7 miss_req", int'(miss_req), 1);
                check(miss_addr == ADDR_W'(a), "R5 miss_addr", int'(miss_addr), a);
                for (int k = 0; k < stall; k++) begin
                    @(posedge clk);
                    #1;
                    check(miss_req == 1'b1 && miss_addr == ADDR_W'(a), "R5 miss held",
                          int'(miss_addr), a);
                    check(way_en == '0, "R5 no enables while waiting", int'(way_en), 0);
                    check(req_ready == 1'b0, "R8 busy in refill", int'(req_ready), 0);
                end
                @(negedge clk);
                fill_valid = 1'b1;
                fill_data  = line_of(a);
                @(posedge clk);
                #1;
                fill_valid = 1'b0;
                check(rsp_valid == 1'b1, "R5 refill rsp_valid", int'(rsp_valid), 1);
                check(rsp_class == 2'd2, "R5 refill class", int'(rsp_class), 2);
                check(rsp_data == line_of(a), "R5 refill data", int'(rsp_data), int'(line_of(a)));
                m_val[s][hw] = 1'b1;
                m_tag[s][hw] = t;
            end
        end
        model_touch(s, hw);
        @(posedge clk);
        #1;
        check(rsp_valid == 1'b0, "R9 single-cycle rsp", int'(rsp_valid), 0);
        check(req_ready == 1'b1, "R8 ready after rsp", int'(req_ready), 1);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_pred[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 1'b0;
                m_tag[s][w] = 0;
                m_age[s][w] = w;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
        check(miss_req == 1'b0, "R1 reset miss_req", int'(miss_req), 0);
        check(way_en == '0, "R1 reset way_en", int'(way_en), 0);

        // Cold sweep: every line misses, later tags evict earlier ones.
        for (int a = 0; a < NADDR; a++) access(a, a % 3);
        // Re-touch the resident tags of each set twice in a row.
        for (int rep = 0; rep < 2; rep++) begin
            for (int t = 12; t < 16; t++) begin
                for (int s = 0; s < SETS; s++) begin
                    access(t * SETS + s, 0);
                    access(t * SETS + s, 0);
                end
            end
        end
        // Strided sweep mixing hits, probe hits and evictions.
        for (int i = 0; i < 256; i++) access((i * 23 + (i / 16) * 5) % NADDR, i % 4);
        // Small working set per set that fits in the ways.
        for (int i = 0; i < 128; i++) access(((i % 3) + 13) * SETS + (i % SETS), 1);
        // Full second sweep in reverse order.
        for (int a = NADDR - 1; a >= 0; a--) access(a, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule